// File: doc/BRIEF.md
# Selectable Clock Divider Tree

This block turns three incoming clock-enable strobes into the enable strobes that a chip's CPU, peripheral bus and peripherals run on. The strobes come from a main oscillator, a PLL and a low-speed source. Everything runs in one fast clock domain. Every input and output is a single-cycle enable and not a real clock.

Two paths feed the base clock:
- The PLL strobe is pre-divided by an even ratio.
- The main strobe is divided by a ratio that may be odd.

A source-select bit picks one of them as the base clock. Two further dividers derive the CPU and peripheral-bus enables from the base clock. In wait mode the base clock is gated off, so both of those enables stop.

The undivided main strobe is the peripheral source. From it the block makes:
- a programmable divide-by-2n prescaler output;
- fixed divide-by-8 and divide-by-32 taps.

The CPU enable can also be taken straight from the low-speed strobe.

Every divider loads a new ratio only when it reaches its own terminal count. A ratio change therefore never produces a shortened period. Each output goes high one fast cycle after the input strobe that completes its count.

Top module: `clkt_tree`

## Requirements
- R1: `pll_div_sel` codes 0, 1, 2, 3 divide the PLL strobe by 2, 4, 6, 8 respectively.
- R2: `base_div_sel` codes 0, 1, 2, 3 divide the main strobe by 2, 3, 4, 6 respectively, with exactly one pulse per period.
- R3: `base_src` = 0 takes the base clock from the divided PLL path; `base_src` = 1 takes it from the divided main path.
- R4: `cpu_div_sel` code k divides the base clock by k+1 to form `cpu_en`.
- R5: `bus_div_sel` codes 0, 1, 2 divide the base clock by 2, 3, 4 to form `bus_en`; code 3 also divides by 4. `bus_en` is never high in two consecutive cycles.
- R6: `fpre_en` divides the main strobe by 2n, where n is `pre_n`. When n = 0, `fpre_en` follows every main strobe.
- R7: `f8_en` and `f32_en` divide the main strobe by 8 and by 32 at all times.
- R8: While `wait_mode` is 1, `cpu_en` and `bus_en` stay low from the next cycle on, and the peripheral outputs keep running.
- R9: A new ratio code is loaded only when the divider completes its current period. The period in progress keeps the old ratio.
- R10: With `cpu_slow` = 1, `cpu_en` follows `slow_tick` one cycle later.
- R11: While `rst` is high, all outputs are low. Every output pulse follows an input strobe in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all logic is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| main_tick | input | 1 | Main oscillator enable strobe |
| pll_tick | input | 1 | PLL enable strobe |
| slow_tick | input | 1 | Low-speed oscillator enable strobe |
| pll_div_sel | input | 2 | PLL pre-divide code (R1) |
| base_div_sel | input | 2 | Main-path divide code (R2) |
| base_src | input | 1 | Base source: 0 PLL path, 1 main path |
| cpu_div_sel | input | 2 | CPU divide code (R4) |
| bus_div_sel | input | 2 | Peripheral-bus divide code (R5) |
| pre_n | input | 4 | Prescaler n, divides by 2n |
| cpu_slow | input | 1 | CPU enable taken from the low-speed strobe |
| wait_mode | input | 1 | Gates the base clock off |
| cpu_en | output | 1 | CPU clock enable |
| bus_en | output | 1 | Peripheral-bus clock enable |
| f8_en | output | 1 | Main strobe divided by 8 |
| f32_en | output | 1 | Main strobe divided by 32 |
| fpre_en | output | 1 | Main strobe divided by 2n |

## Verification
The deferred ratio load is the hardest behaviour to reach. With free-running strobes it is hidden, because a divider simply settles to the new ratio a period later. The bench therefore resets the prescaler with a ratio of 6 and the main strobe held low, writes a ratio of 2, and then issues single main strobes one at a time. It counts pulses after each strobe: none may appear before the sixth strobe, and the next one must appear two strobes later. The remaining period checks let each configuration settle for three pulses and then measure the gap to the fourth.

// File: rtl/clkt_pkg.sv
package clkt_pkg;

    // Ratio counters must hold 2*(2**PRE_W-1) and the fixed tap of 32.
    parameter int PRE_W   = 4;
    parameter int CLKT_RW = 6;
    parameter int N_TAPS  = 2;

    typedef logic [CLKT_RW-1:0] ratio_t;

    typedef struct packed {
        logic cpu;
        logic bus;
        logic f8;
        logic f32;
        logic fpre;
    } strobe_t;

    function automatic ratio_t pll_ratio(input logic [1:0] code);
        unique case (code)
            2'd0:    return ratio_t'(2);
            2'd1:    return ratio_t'(4);
            2'd2:    return ratio_t'(6);
            default: return ratio_t'(8);
        endcase
    endfunction

    function automatic ratio_t base_ratio(input logic [1:0] code);
        unique case (code)
            2'd0:    return ratio_t'(2);
            2'd1:    return ratio_t'(3);
            2'd2:    return ratio_t'(4);
            default: return ratio_t'(6);
        endcase
    endfunction

    function automatic ratio_t cpu_ratio(input logic [1:0] code);
        return ratio_t'(code) + ratio_t'(1);
    endfunction

    function automatic ratio_t bus_ratio(input logic [1:0] code);
        unique case (code)
            2'd0:    return ratio_t'(2);
            2'd1:    return ratio_t'(3);
            default: return ratio_t'(4);
        endcase
    endfunction

    function automatic ratio_t pre_ratio(input logic [PRE_W-1:0] n);
        if (n == '0) return ratio_t'(1);
        return ratio_t'({n, 1'b0});
    endfunction

endpackage

// File: rtl/clkt_divider.sv
module clkt_divider #(
    parameter int RW = clkt_pkg::CLKT_RW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [RW-1:0] ratio,
    output logic          pulse
);
    logic [RW-1:0] lim_q;
    logic [RW-1:0] cnt_q;
    logic          term;

    assign term = tick && (cnt_q == lim_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= ratio - 1'b1;
            pulse <= 1'b0;
        end else begin
            pulse <= term;
            if (term) begin
                cnt_q <= '0;
                lim_q <= ratio - 1'b1;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R11
    pulse_follows_tick_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |-> $past(tick));

    // R9
    limit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !term |=> $stable(lim_q));

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= lim_q);

endmodule

// File: rtl/clkt_base_stage.sv
module clkt_base_stage (
    input  logic clk,
    input  logic rst,
    input  logic pll_div_en,
    input  logic main_div_en,
    input  logic base_src,
    input  logic wait_mode,
    input  logic slow_tick,
    output logic base_en,
    output logic slow_en
);
    logic src_pick;

    always_comb begin
        src_pick = base_src ? main_div_en : pll_div_en;
        base_en  = src_pick && !wait_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) slow_en <= 1'b0;
        else     slow_en <= slow_tick && !wait_mode;
    end

endmodule

// File: rtl/clkt_tree.sv
module clkt_tree
    import clkt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             main_tick,
    input  logic             pll_tick,
    input  logic             slow_tick,
    input  logic [1:0]       pll_div_sel,
    input  logic [1:0]       base_div_sel,
    input  logic             base_src,
    input  logic [1:0]       cpu_div_sel,
    input  logic [1:0]       bus_div_sel,
    input  logic [PRE_W-1:0] pre_n,
    input  logic             cpu_slow,
    input  logic             wait_mode,
    output logic             cpu_en,
    output logic             bus_en,
    output logic             f8_en,
    output logic             f32_en,
    output logic             fpre_en
);
    localparam ratio_t TAP_RATIO [N_TAPS] = '{ratio_t'(8), ratio_t'(32)};

    logic          pll_div_en, main_div_en, base_en, slow_en, cpu_div_en;
    logic [N_TAPS-1:0] tap_en;
    strobe_t       st;

    clkt_divider u_pll_div (
        .clk(clk), .rst(rst), .tick(pll_tick),
        .ratio(pll_ratio(pll_div_sel)), .pulse(pll_div_en));

    clkt_divider u_main_div (
        .clk(clk), .rst(rst), .tick(main_tick),
        .ratio(base_ratio(base_div_sel)), .pulse(main_div_en));

    clkt_base_stage u_base (
        .clk(clk), .rst(rst), .pll_div_en(pll_div_en),
        .main_div_en(main_div_en), .base_src(base_src),
        .wait_mode(wait_mode), .slow_tick(slow_tick),
        .base_en(base_en), .slow_en(slow_en));

    clkt_divider u_cpu_div (
        .clk(clk), .rst(rst), .tick(base_en),
        .ratio(cpu_ratio(cpu_div_sel)), .pulse(cpu_div_en));

    clkt_divider u_bus_div (
        .clk(clk), .rst(rst), .tick(base_en),
        .ratio(bus_ratio(bus_div_sel)), .pulse(st.bus));

    clkt_divider u_pre_div (
        .clk(clk), .rst(rst), .tick(main_tick),
        .ratio(pre_ratio(pre_n)), .pulse(st.fpre));

    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        clkt_divider u_tap (
            .clk(clk), .rst(rst), .tick(main_tick),
            .ratio(TAP_RATIO[i]), .pulse(tap_en[i]));
    end

    always_comb begin
        st.cpu = cpu_slow ? slow_en : cpu_div_en;
        st.f8  = tap_en[0];
        st.f32 = tap_en[1];
    end

    assign cpu_en  = st.cpu;
    assign bus_en  = st.bus;
    assign f8_en   = st.f8;
    assign f32_en  = st.f32;
    assign fpre_en = st.fpre;

    // R8
    wait_stops_core_chk: assert property (@(posedge clk) disable iff (rst)
        wait_mode |=> (!cpu_en && !bus_en));

    // R5
    bus_single_chk: assert property (@(posedge clk) disable iff (rst)
        bus_en |=> !bus_en);

    // R7
    f8_single_chk: assert property (@(posedge clk) disable iff (rst)
        f8_en |=> !f8_en);

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !(cpu_en || bus_en || f8_en || f32_en || fpre_en));

endmodule

// File: tb/sim_clkt_tree.sv
module sim_clkt_tree;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic main_tick = 1'b1, pll_tick = 1'b1, slow_tick = 1'b0;
    logic [1:0] pll_div_sel = 2'd0, base_div_sel = 2'd0;
    logic [1:0] cpu_div_sel = 2'd0, bus_div_sel = 2'd0;
    logic base_src = 1'b0, cpu_slow = 1'b0, wait_mode = 1'b0;
    logic [3:0] pre_n = 4'd0;
    logic cpu_en, bus_en, f8_en, f32_en, fpre_en;

    int checks = 0, fails = 0, cyc = 0, slow_k = 0, pre_cnt = 0;
    bit slow_run = 1'b0, busy = 1'b0, done = 1'b0;
    int q_idx[$];
    int q_exp[$];
    string q_tag[$];

    clkt_tree u0 (
        .clk(clk), .rst(rst), .main_tick(main_tick), .pll_tick(pll_tick),
        .slow_tick(slow_tick), .pll_div_sel(pll_div_sel),
        .base_div_sel(base_div_sel), .base_src(base_src),
        .cpu_div_sel(cpu_div_sel), .bus_div_sel(bus_div_sel), .pre_n(pre_n),
        .cpu_slow(cpu_slow), .wait_mode(wait_mode), .cpu_en(cpu_en),
        .bus_en(bus_en), .f8_en(f8_en), .f32_en(f32_en), .fpre_en(fpre_en));

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (fpre_en) pre_cnt <= pre_cnt + 1;

    initial forever begin
        @(posedge clk); #1;
        slow_tick = slow_run && (slow_k % 5 == 0);
        slow_k++;
    end

    function automatic logic sig(input int idx);
        case (idx)
            0: return cpu_en;
            1: return bus_en;
            2: return f8_en;
            3: return f32_en;
            default: return fpre_en;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pops expected intervals, skips three settling pulses, measures the next gap.
    initial forever begin
        int idx, exp, n, last, iv, guard;
        string tag;
        while (q_idx.size() == 0) @(posedge clk);
        busy = 1'b1;
        idx = q_idx.pop_front(); exp = q_exp.pop_front(); tag = q_tag.pop_front();
        n = 0; last = 0; iv = -1; guard = 0;
        while (n < 4 && guard < 3000) begin
            @(negedge clk);
            guard++;
            if (sig(idx)) begin
                n++;
                if (n == 3) last = cyc;
                if (n == 4) iv = cyc - last;
            end
        end
        check(iv == exp, tag, iv, exp);
        busy = 1'b0;
    end

    task automatic expect_iv(input int idx, input int exp, input string tag);
        q_idx.push_back(idx); q_exp.push_back(exp); q_tag.push_back(tag);
        @(posedge clk);
        while (q_idx.size() != 0 || busy) @(posedge clk);
        #1;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic count_win(input int idx, input int len, output int c);
        c = 0;
        repeat (len) begin
            @(negedge clk);
            if (sig(idx)) c++;
        end
    endtask

    task automatic one_main_tick;
        @(posedge clk); #1 main_tick = 1'b1;
        @(posedge clk); #1 main_tick = 1'b0;
    endtask

    initial begin
        int c;
        // R11: outputs low in reset while strobes run
        repeat (4) @(negedge clk);
        check({cpu_en, bus_en, f8_en, f32_en, fpre_en} == 5'b0, "R11 reset",
              int'({cpu_en, bus_en, f8_en, f32_en, fpre_en}), 0);
        step(1); rst = 1'b0;

        // R1 R4 R5: PLL /2, cpu /1, bus /2
        expect_iv(0, 2, "R1 R4 cpu p2 m1");
        expect_iv(1, 4, "R5 bus p2 q2");
        pll_div_sel = 2'd3; cpu_div_sel = 2'd3; bus_div_sel = 2'd2;
        expect_iv(0, 32, "R1 R4 cpu p8 m4");
        expect_iv(1, 32, "R5 bus p8 q4");
        // R2 R3: main path
        base_src = 1'b1; base_div_sel = 2'd1; cpu_div_sel = 2'd1; bus_div_sel = 2'd1;
        expect_iv(0, 6, "R2 R3 cpu b3 m2");
        expect_iv(1, 9, "R2 R5 bus b3 q3");
        base_div_sel = 2'd3; cpu_div_sel = 2'd0; bus_div_sel = 2'd3;
        expect_iv(0, 6, "R2 R3 cpu b6 m1");
        expect_iv(1, 24, "R5 bus b6 code3");
        // R7 fixed taps
        expect_iv(2, 8, "R7 f8");
        expect_iv(3, 32, "R7 f32");
        // R6 prescaler
        pre_n = 4'd0;  expect_iv(4, 1, "R6 n0 bypass");
        pre_n = 4'd5;  expect_iv(4, 10, "R6 n5");
        pre_n = 4'd15; expect_iv(4, 30, "R6 n15");
        // R10 slow source
        slow_run = 1'b1; cpu_slow = 1'b1;
        expect_iv(0, 5, "R10 slow cpu");
        cpu_slow = 1'b0; slow_run = 1'b0;

        // R8 wait mode
        base_src = 1'b0; pll_div_sel = 2'd0; cpu_div_sel = 2'd0;
        step(20);
        wait_mode = 1'b1; step(3);
        count_win(0, 96, c); check(c == 0, "R8 cpu in wait", c, 0);
        count_win(1, 96, c); check(c == 0, "R8 bus in wait", c, 0);
        count_win(2, 96, c); check(c == 12, "R8 f8 in wait", c, 12);
        wait_mode = 1'b0;
        expect_iv(0, 2, "R8 cpu after wait");

        // R9 deferred ratio load on the prescaler
        main_tick = 1'b0; pre_n = 4'd3; rst = 1'b1;
        step(3); rst = 1'b0; pre_n = 4'd1;
        step(2); pre_cnt = 0;
        repeat (5) one_main_tick;
        step(2);
        check(pre_cnt == 0, "R9 old ratio kept", pre_cnt, 0);
        one_main_tick; step(2);
        check(pre_cnt == 1, "R9 terminal at old ratio", pre_cnt, 1);
        repeat (2) one_main_tick;
        step(2);
        check(pre_cnt == 2, "R9 new ratio after load", pre_cnt, 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule